// File: doc/BRIEF.md
# Segmented Page-Table Miss Handler

This block resolves a translation miss for a 32-bit virtual address space with 4 KB pages, where the page table is not one linear array but three separate tables, one per segment. The top two address bits pick the segment (code, heap or stack, with the all-zero pattern left unused). Each segment has its own base register, which gives the byte address of its table, and its own bounds register, which counts how many entries that table holds.

A faulting address arrives on a valid/ready request port. The block splits the address into segment number and 18-bit page number and checks the page number against the segment's bounds. If the checks pass, it forms the entry address and issues one read on a memory request port. It then returns either the frame number from the fetched entry or a fault code on a valid/ready response port. Software loads the base and bounds registers through a simple write port. Only one translation is in flight at any time.

Top module: `sptw_miss_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, and every base and bounds register holds 0. A request to any segment before configuration therefore ends in a bounds fault.
- R2: A request whose address bits [31:30] are 00 completes with status 1 (segment fault) and frame 0, and no memory read is issued for it.
- R3: With the page number taken from address bits [29:12], a page number greater than or equal to the selected segment's bounds value completes with status 2 (bounds fault) and issues no memory read. A page number one below the bounds value is translated.
- R4: For a request that passes the checks, `mem_rd_addr` equals the segment's base plus four times the page number, modulo 2^32.
- R5: When the fetched entry has bit 31 set, the response has status 0 (success) and `rsp_pfn` equals entry bits [19:0]. Entry bits [30:20] have no effect on the response.
- R6: When the fetched entry has bit 31 clear, the response has status 3 (page fault) and frame 0.
- R7: From the cycle a request is accepted until the cycle its response is taken, `req_ready` is 0. A response whose `rsp_ready` is low stays valid with unchanged status and frame.
- R8: A read whose `mem_rd_ready` is low stays valid with an unchanged address.
- R9: A register write that lands in the same cycle as a request is accepted does not affect that request; it does affect the next one.
- R10: A register write addressed to segment 00 changes no register. Translations for segments 01, 10 and 11 are the same as before it.
- R11: Every fault status (1, 2 or 3) is reported with `rsp_pfn` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_seg | input | 2 | Segment whose register is written (00 discarded) |
| cfg_wr_bnd | input | 1 | 1 selects the bounds register, 0 selects the base register |
| cfg_wr_data | input | 32 | Value written |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Miss request accepted when high with req_valid |
| req_vaddr | input | 32 | Faulting virtual address |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the page table entry |
| mem_rsp_valid | input | 1 | Read data returned (used only while awaiting it) |
| mem_rsp_data | input | 32 | Fetched entry: bit 31 valid, bits [19:0] frame |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_status | output | 2 | 0 ok, 1 segment fault, 2 bounds fault, 3 page fault |
| rsp_pfn | output | 20 | Physical frame number (0 on a fault) |

## Verification
A register write and the acceptance of a request can fall on the same clock edge. When the write targets the segment being translated, it raises the question of whether the translation sees the old bounds or the new one. The bench provokes this by driving a bounds write of zero on the same cycle as a request to a page inside the old bounds. It judges the result by two facts: the entry read must still appear at the expected address, and a second request to the same page must then end in a bounds fault. A second overlap, a response held by a slow consumer while a new request is offered, is judged by `req_ready` staying low and the held result not changing.

// File: rtl/sptw_pkg.sv
package sptw_pkg;

  typedef enum logic [1:0] {
    XS_OK   = 2'd0,
    XS_SEG  = 2'd1,
    XS_BND  = 2'd2,
    XS_PAGE = 2'd3
  } xlat_status_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ISSUE,
    WS_WAIT,
    WS_RESP
  } walk_state_e;

endpackage

// File: rtl/sptw_seg_regs.sv
module sptw_seg_regs #(
  parameter int VA_W  = 32,
  parameter int SEG_W = 2,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEG_W-1:0]           wr_seg,
  input  logic                       wr_bnd,
  input  logic [VA_W-1:0]            wr_data,
  output logic [NSEG-1:0][VA_W-1:0]  base_all,
  output logic [NSEG-1:0][VA_W-1:0]  bnd_all
);

  // Segment 0 owns no storage; its slots read as zero.
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s == 0) begin : g_null
      assign base_all[s] = '0;
      assign bnd_all[s]  = '0;
    end else begin : g_live
      logic [VA_W-1:0] base_q;
      logic [VA_W-1:0] bnd_q;
      logic            hit;

      assign hit = wr_en && (wr_seg == SEG_W'(s));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q <= '0;
          bnd_q  <= '0;
        end else if (hit) begin
          if (wr_bnd) bnd_q  <= wr_data;
          else        base_q <= wr_data;
        end
      end

      assign base_all[s] = base_q;
      assign bnd_all[s]  = bnd_q;
    end
  end

endmodule

// File: rtl/sptw_va_decode.sv
module sptw_va_decode #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SEG_W  = 2,
  parameter int PTE_LG = 2,
  localparam int NSEG  = 1 << SEG_W,
  localparam int VPN_W = VA_W - SEG_W - OFF_W
) (
  input  logic [VA_W-1:0]            vaddr,
  input  logic [NSEG-1:0][VA_W-1:0]  base_all,
  input  logic [NSEG-1:0][VA_W-1:0]  bnd_all,
  output logic [SEG_W-1:0]           seg_idx,
  output logic [VPN_W-1:0]           vpn,
  output logic                       seg_null,
  output logic                       bnd_fault,
  output logic [VA_W-1:0]            pte_addr
);

  function automatic logic [SEG_W-1:0] f_seg(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: SEG_W];
  endfunction

  function automatic logic [VPN_W-1:0] f_vpn(input logic [VA_W-1:0] va);
    return va[OFF_W +: VPN_W];
  endfunction

  // Entry address: table base plus page number scaled by entry size.
  function automatic logic [VA_W-1:0] f_pte_addr(input logic [VA_W-1:0] base,
                                                 input logic [VPN_W-1:0] pn);
    logic [VA_W-1:0] scaled;
    scaled = {{(VA_W-VPN_W-PTE_LG){1'b0}}, pn, {PTE_LG{1'b0}}};
    return base + scaled;
  endfunction

  // Bounds value counts valid entries, so pn == bounds is already outside.
  function automatic logic f_over(input logic [VPN_W-1:0] pn,
                                  input logic [VA_W-1:0]  bnd);
    return {{(VA_W-VPN_W){1'b0}}, pn} >= bnd;
  endfunction

  logic [OFF_W-1:0] unused_offset;
  assign unused_offset = vaddr[OFF_W-1:0];

  always_comb begin
    seg_idx   = f_seg(vaddr);
    vpn       = f_vpn(vaddr);
    seg_null  = (seg_idx == '0);
    bnd_fault = f_over(vpn, bnd_all[seg_idx]);
    pte_addr  = f_pte_addr(base_all[seg_idx], vpn);
  end

endmodule

// File: rtl/sptw_walk_ctl.sv
module sptw_walk_ctl
  import sptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PFN_W   = 20,
  parameter int VLD_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              seg_null,
  input  logic              bnd_fault,
  input  logic [VA_W-1:0]   pte_addr_in,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [VA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              acc_evt,
  output logic              rd_fire,
  output logic              pte_take,
  output logic              rsp_fire
);

  walk_state_e   state_q;
  logic [VA_W-1:0]  addr_q;
  xlat_status_e  st_q;
  logic [PFN_W-1:0] pfn_q;
  logic          pte_ok;

  logic unused_data;
  assign unused_data = ^{mem_rsp_data[VA_W-1:PFN_W]};

  assign req_ready    = (state_q == WS_IDLE);
  assign mem_rd_valid = (state_q == WS_ISSUE);
  assign rsp_valid    = (state_q == WS_RESP);
  assign mem_rd_addr  = addr_q;
  assign rsp_status   = st_q;
  assign rsp_pfn      = pfn_q;

  assign acc_evt  = req_valid && req_ready;
  assign rd_fire  = mem_rd_valid && mem_rd_ready;
  assign pte_take = (state_q == WS_WAIT) && mem_rsp_valid;
  assign rsp_fire = rsp_valid && rsp_ready;
  assign pte_ok   = mem_rsp_data[VLD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      addr_q  <= '0;
      st_q    <= XS_OK;
      pfn_q   <= '0;
    end else begin
      unique case (state_q)
        WS_IDLE: begin
          if (acc_evt) begin
            addr_q <= pte_addr_in;
            pfn_q  <= '0;
            if (seg_null) begin
              st_q    <= XS_SEG;
              state_q <= WS_RESP;
            end else if (bnd_fault) begin
              st_q    <= XS_BND;
              state_q <= WS_RESP;
            end else begin
              st_q    <= XS_OK;
              state_q <= WS_ISSUE;
            end
          end
        end
        WS_ISSUE: begin
          if (rd_fire) state_q <= WS_WAIT;
        end
        WS_WAIT: begin
          if (pte_take) begin
            if (pte_ok) begin
              st_q  <= XS_OK;
              pfn_q <= mem_rsp_data[PFN_W-1:0];
            end else begin
              st_q  <= XS_PAGE;
              pfn_q <= '0;
            end
            state_q <= WS_RESP;
          end
        end
        WS_RESP: begin
          if (rsp_fire) state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sptw_miss_unit.sv
module sptw_miss_unit #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int SEG_W   = 2,
  parameter int PTE_LG  = 2,
  parameter int PFN_W   = 20,
  parameter int VLD_BIT = 31,
  localparam int NSEG   = 1 << SEG_W,
  localparam int VPN_W  = VA_W - SEG_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEG_W-1:0]  cfg_wr_seg,
  input  logic              cfg_wr_bnd,
  input  logic [VA_W-1:0]   cfg_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [VA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [PFN_W-1:0]  rsp_pfn
);

  logic [NSEG-1:0][VA_W-1:0] base_all;
  logic [NSEG-1:0][VA_W-1:0] bnd_all;
  logic [SEG_W-1:0]          seg_idx;
  logic [VPN_W-1:0]          vpn;
  logic                      seg_null;
  logic                      bnd_fault;
  logic [VA_W-1:0]           pte_addr;

  // Named events, brought out for the checker.
  logic acc_evt;
  logic rd_fire;
  logic pte_take;
  logic rsp_fire;

  logic unused_dec;
  assign unused_dec = ^{seg_idx, vpn, rd_fire, rsp_fire};

  sptw_seg_regs #(.VA_W(VA_W), .SEG_W(SEG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_seg   (cfg_wr_seg),
    .wr_bnd   (cfg_wr_bnd),
    .wr_data  (cfg_wr_data),
    .base_all (base_all),
    .bnd_all  (bnd_all)
  );

  sptw_va_decode #(
    .VA_W(VA_W), .OFF_W(OFF_W), .SEG_W(SEG_W), .PTE_LG(PTE_LG)
  ) u_dec (
    .vaddr     (req_vaddr),
    .base_all  (base_all),
    .bnd_all   (bnd_all),
    .seg_idx   (seg_idx),
    .vpn       (vpn),
    .seg_null  (seg_null),
    .bnd_fault (bnd_fault),
    .pte_addr  (pte_addr)
  );

  sptw_walk_ctl #(.VA_W(VA_W), .PFN_W(PFN_W), .VLD_BIT(VLD_BIT)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .seg_null      (seg_null),
    .bnd_fault     (bnd_fault),
    .pte_addr_in   (pte_addr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_status    (rsp_status),
    .rsp_pfn       (rsp_pfn),
    .acc_evt       (acc_evt),
    .rd_fire       (rd_fire),
    .pte_take      (pte_take),
    .rsp_fire      (rsp_fire)
  );

endmodule

// File: rtl/sptw_chk.sv
module sptw_chk #(
  parameter int VA_W    = 32,
  parameter int SEG_W   = 2,
  parameter int PFN_W   = 20,
  parameter int VLD_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [VA_W-1:0]   mem_rd_addr,
  input logic [VA_W-1:0]   mem_rsp_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_status,
  input logic [PFN_W-1:0]  rsp_pfn,
  input logic              acc_evt,
  input logic              bnd_fault,
  input logic              pte_take
);

  // R2
  seg_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && req_vaddr[VA_W-1 -: SEG_W] == '0)
      |=> (rsp_valid && rsp_status == 2'd1 && !mem_rd_valid));

  // R3
  bnd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && bnd_fault && req_vaddr[VA_W-1 -: SEG_W] != '0)
      |=> (rsp_valid && rsp_status == 2'd2 && !mem_rd_valid));

  // R5
  pte_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_take |=> (rsp_valid &&
                  rsp_status == ($past(mem_rsp_data[VLD_BIT]) ? 2'd0 : 2'd3)));

  // R7
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !req_ready);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
      |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_pfn)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R11
  fault_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_pfn == '0));

endmodule

bind sptw_miss_unit sptw_chk #(
  .VA_W(VA_W), .SEG_W(SEG_W), .PFN_W(PFN_W), .VLD_BIT(VLD_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_vaddr    (req_vaddr),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rsp_data (mem_rsp_data),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_status   (rsp_status),
  .rsp_pfn      (rsp_pfn),
  .acc_evt      (acc_evt),
  .bnd_fault    (bnd_fault),
  .pte_take     (pte_take)
);

// File: tb/sim_sptw_miss_unit.sv
`timescale 1ns/1ps
module sim_sptw_miss_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_seg = '0;
  logic        cfg_wr_bnd = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_status;
  logic [19:0] rsp_pfn;

  int checks = 0;
  int failures = 0;

  logic [31:0] sh_base [4];
  logic [31:0] sh_bnd  [4];

  always #2 clk = ~clk;

  sptw_miss_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_seg(cfg_wr_seg),
    .cfg_wr_bnd(cfg_wr_bnd), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_pfn(rsp_pfn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model, written with masks and division rather than slices.
  function automatic logic [1:0] m_status(input logic [31:0] va, input logic [31:0] pte);
    int unsigned sn;
    int unsigned pn;
    sn = (va & 32'hC000_0000) >> 30;
    pn = (va & 32'h3FFF_F000) >> 12;
    if (sn == 0) return 2'd1;
    if (pn >= sh_bnd[sn]) return 2'd2;
    return (pte / 32'h8000_0000 == 1) ? 2'd0 : 2'd3;
  endfunction

  function automatic logic [31:0] m_addr(input logic [31:0] va);
    int unsigned sn;
    int unsigned pn;
    sn = (va & 32'hC000_0000) >> 30;
    pn = (va & 32'h3FFF_F000) >> 12;
    return sh_base[sn] + pn * 4;
  endfunction

  task automatic cfg(input logic [1:0] seg, input bit bnd, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_seg = seg; cfg_wr_bnd = bnd; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (seg != 0) begin
      if (bnd) sh_bnd[seg] = d; else sh_base[seg] = d;
    end
  endtask

  // One full translation. Optionally drives a register write on the accept cycle.
  task automatic run(input logic [31:0] va, input logic [31:0] pte, input int stall,
                     input string req, input bit wr_same, input logic [1:0] wseg,
                     input bit wbnd, input logic [31:0] wdata);
    logic [1:0]  e_st;
    logic [31:0] e_addr;
    logic [19:0] e_pfn;
    bit          e_rd;
    e_st   = m_status(va, pte);
    e_addr = m_addr(va);
    e_pfn  = (e_st == 2'd0) ? 20'(pte % 32'h0010_0000) : 20'd0;
    e_rd   = (e_st == 2'd0) || (e_st == 2'd3);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va;
    if (wr_same) begin
      cfg_wr_en = 1'b1; cfg_wr_seg = wseg; cfg_wr_bnd = wbnd; cfg_wr_data = wdata;
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_wr_en = 1'b0;
    if (wr_same && wseg != 0) begin
      if (wbnd) sh_bnd[wseg] = wdata; else sh_base[wseg] = wdata;
    end
    if (e_rd) begin
      chk(mem_rd_valid == 1'b1, req, "read issued", 32'(mem_rd_valid), 32'd1);
      chk(mem_rd_addr == e_addr, "R4", "entry address", mem_rd_addr, e_addr);
      for (int i = 0; i < stall; i++) begin
        req_valid = 1'b1;
        @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == e_addr, "R8", "read held",
            mem_rd_addr, e_addr);
        chk(req_ready == 1'b0, "R7", "busy during read", 32'(req_ready), 32'd0);
      end
      req_valid = 1'b0;
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end else begin
      chk(mem_rd_valid == 1'b0, req, "no read on fault", 32'(mem_rd_valid), 32'd0);
    end
    chk(rsp_valid == 1'b1, req, "response valid", 32'(rsp_valid), 32'd1);
    chk(rsp_status == e_st, req, "status", 32'(rsp_status), 32'(e_st));
    chk(rsp_pfn == e_pfn, (e_st == 0) ? req : "R11", "frame", 32'(rsp_pfn), 32'(e_pfn));
    for (int i = 0; i < stall; i++) begin
      req_valid = 1'b1;
      @(negedge clk);
      chk(rsp_valid && rsp_status == e_st && rsp_pfn == e_pfn, "R7", "response held",
          32'(rsp_pfn), 32'(e_pfn));
      chk(req_ready == 1'b0, "R7", "busy while holding", 32'(req_ready), 32'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R7", "idle after take",
        32'({rsp_valid, req_ready}), 32'b01);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin sh_base[s] = '0; sh_bnd[s] = '0; end
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid", 32'(mem_rd_valid), 32'd0);
    // Unconfigured segments: bounds 0, so a bounds fault is expected
    run(32'h4000_0000, 32'h0, 0, "R1", 1'b0, 2'd0, 1'b0, 32'h0);
    run(32'hC000_5000, 32'h0, 0, "R1", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_config;
    cfg(2'd1, 1'b0, 32'h0010_0000); cfg(2'd1, 1'b1, 32'd16);
    cfg(2'd2, 1'b0, 32'h0020_0000); cfg(2'd2, 1'b1, 32'd4);
    cfg(2'd3, 1'b0, 32'hFFFF_FFF0); cfg(2'd3, 1'b1, 32'h0004_0000);
  endtask

  task automatic t_seg_null;
    run(32'h0000_1234, 32'h8000_0001, 0, "R2", 1'b0, 2'd0, 1'b0, 32'h0);
    run(32'h3FFF_FFFF, 32'h8000_0001, 1, "R2", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_hit;
    run(32'h4000_3ABC, 32'h8001_2345, 0, "R5", 1'b0, 2'd0, 1'b0, 32'h0);
    // bits [30:20] set must not leak into the frame
    run(32'h4000_0000, 32'hFFF0_0007, 0, "R5", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_invalid_stall;
    run(32'h8000_3000, 32'h7FFF_FABC, 2, "R6", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_bound_edge;
    run(32'h8000_4000, 32'h8000_0001, 0, "R3", 1'b0, 2'd0, 1'b0, 32'h0);
    run(32'h4000_F000, 32'h8000_00AA, 0, "R3", 1'b0, 2'd0, 1'b0, 32'h0);
    run(32'h4001_0000, 32'h8000_00AA, 0, "R3", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_wrap;
    // base 0xFFFFFFF0 + 4*0x3FFFF wraps to 0x000FFFEC
    run(32'hFFFF_F000, 32'hFFFF_FFFF, 1, "R4", 1'b0, 2'd0, 1'b0, 32'h0);
    chk(m_addr(32'hFFFF_F000) == 32'h000F_FFEC, "R4", "model wrap", m_addr(32'hFFFF_F000),
        32'h000F_FFEC);
  endtask

  task automatic t_seg0_write;
    cfg(2'd0, 1'b0, 32'hDEAD_0000);
    cfg(2'd0, 1'b1, 32'd0);
    run(32'h4000_5000, 32'h8000_0055, 0, "R10", 1'b0, 2'd0, 1'b0, 32'h0);
    run(32'h8000_1000, 32'h8000_0066, 0, "R10", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic t_same_cycle;
    // bounds of segment 1 drop to 0 on the accept edge: this request still reads
    run(32'h4000_5000, 32'h8000_0321, 0, "R9", 1'b1, 2'd1, 1'b1, 32'd0);
    run(32'h4000_5000, 32'h8000_0321, 0, "R9", 1'b0, 2'd0, 1'b0, 32'h0);
    chk(sh_bnd[1] == 32'd0, "R9", "model bounds updated", sh_bnd[1], 32'd0);
    cfg(2'd1, 1'b1, 32'd16);
    // base write on the accept edge: old base used, then new base
    run(32'h4000_2000, 32'h8000_0777, 0, "R9", 1'b1, 2'd1, 1'b0, 32'h0030_0000);
    run(32'h4000_2000, 32'h8000_0777, 0, "R9", 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_seg_null();
    t_hit();
    t_invalid_stall();
    t_bound_edge();
    t_wrap();
    t_seg0_write();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule